// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block times one conversion of a successive-approximation converter. It counts half periods of the converter clock from the start of a conversion. From that count it produces a single sample-and-hold strobe, one strobe per result bit (most significant first), a result-load pulse and a sticky completion flag. A conversion starts in one of three ways: a software write to the start bit, a rising edge on a trigger input when triggering is enabled, or an immediate restart in free-running mode.

The conversion type sets the timing. The first conversion after the converter is enabled is the long one, because the analog front end settles during it. Triggered conversions sample half a cycle later than software-started ones. Differential conversions are aligned to a clock at half the converter rate: a start that lands in the wrong half of that slow clock is delayed by one converter cycle.

The prescaler, the comparator and the DAC sit outside this block. The prescaler supplies a strobe, `tick_half`, that marks each half period of the converter clock. The block asks for a prescaler reset when a trigger starts a conversion. It also marks each conversion start so that the channel and reference selection can be latched.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst_n` is low, and on the cycle after its release, all outputs are 0.
- R2: The first conversion after `adc_en` rises places the sample strobe 27 half-ticks after the start edge and the result load 50 half-ticks after it.
- R3: A software-started single-ended conversion places the sample strobe at 3 half-ticks and the result load at 26 half-ticks.
- R4: With `auto_en` high, a rising edge of `trig_in` while idle starts a conversion with the sample strobe at 4 half-ticks and the load at 27. `psc_reset` pulses on the cycle after the start edge. A trigger edge while `auto_en` is low starts nothing.
- R5: The phase of the half-rate clock is a 2-bit count of half-ticks. It is held at 0 while `adc_en` is low and advances on every half-tick while `adc_en` is high. When `diff_sel` is high, a start edge seen with phase bit 1 equal to 0 gives sample and load at 3 and 26 half-ticks. A start edge seen with phase bit 1 equal to 1 gives 5 and 28, whichever way the conversion was started.
- R6: After the sample strobe, `bit_strobe` pulses every 2 half-ticks, 10 times in all. `bit_idx` runs from 9 down to 0. The sample, bit and load strobes never overlap.
- R7: `done_flag` rises in the same cycle as `result_load` and stays high until a cycle in which `done_clr` is high. If a load and `done_clr` occur in the same cycle, the load wins.
- R8: `start_bit` reads 1 from the start edge until the end of the conversion, then reads 0. A start write during a conversion is ignored.
- R9: In free-running mode, a conversion restarts in the same edge that loads the previous result. `chan_latch` and `busy` stay high there, and successive loads are 26 half-ticks apart.
- R10: Dropping `adc_en` aborts a conversion on the next edge with no load. The next conversion after re-enabling is again the long first conversion.
- R11: Only edges with `tick_half` high advance the sequence, so the half-tick counts of R2 to R5 hold for any spacing of the strobe.
- R12: `chan_latch` pulses for one cycle right after every start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_en | input | 1 | Converter enable; low aborts and rearms the first-conversion timing |
| tick_half | input | 1 | Strobe marking each half period of the converter clock |
| start_wr | input | 1 | Software write of 1 to the start bit |
| auto_en | input | 1 | Enables trigger-started conversions |
| trig_in | input | 1 | Trigger source level; a rising edge starts a conversion |
| free_run | input | 1 | Restart at once after each conversion |
| diff_sel | input | 1 | Differential channel selected |
| done_clr | input | 1 | Write-one-to-clear for the completion flag |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| bit_strobe | output | 1 | Per-bit approximation strobe |
| bit_idx | output | 4 | Index of the bit being decided |
| busy | output | 1 | Conversion in progress |
| start_bit | output | 1 | Read value of the start bit |
| result_load | output | 1 | Load the result register |
| done_flag | output | 1 | Sticky completion flag |
| chan_latch | output | 1 | Latch the channel and reference selection |
| psc_reset | output | 1 | Request a prescaler reset on a trigger start |

## Verification
The assertions assume the following about the inputs:
- `tick_half` is a strobe driven by a free-running prescaler.
- `done_clr` is a write pulse.
- `adc_en` may fall at any time, and that abort is treated as legal.
- `trig_in` is already synchronous to `clk`.

The stimulus changes every input only at the falling clock edge. It raises `trig_in` only while `auto_en` is set or while the bench checks that a trigger is ignored. It keeps `tick_half` high except in the spacing test, which toggles it every cycle. Differential starts are placed by a phase model kept in the bench, so that both alignments are hit deliberately.

// File: rtl/adcseq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package adcseq_pkg;

    // Timing class of a conversion, chosen at its start edge.
    typedef enum logic [1:0] {
        KIND_NORM  = 2'd0,
        KIND_FIRST = 2'd1,
        KIND_AUTO  = 2'd2,
        KIND_DIFF  = 2'd3
    } conv_kind_e;

endpackage

// File: rtl/adcseq_phase.sv
// Phase counter of the half-rate clock used to align differential starts.
// Counts half-ticks while enabled and is held at zero while disabled.
// Assumes tick_half_i is a single-cycle strobe per half converter period.
module adcseq_phase #(
    parameter int PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_half_i,
    output logic misalign_o
);
    logic [PH_W-1:0] ph_q;

    // Advance the phase on each half-tick; clear while the converter is off.
    always_ff @(posedge clk) begin
        if (!rst_n)           ph_q <= '0;
        else if (!en_i)       ph_q <= '0;
        else if (tick_half_i) ph_q <= ph_q + {{(PH_W-1){1'b0}}, 1'b1};
    end

    // The upper phase bit marks the late half of the slow clock.
    assign misalign_o = ph_q[PH_W-1];
endmodule

// File: rtl/adcseq_launch.sv
// Start arbitration: software start bit, trigger edges, free-running restart.
// Also picks the timing class and tracks the pending long first conversion.
// Assumes trig_i is synchronous to clk; busy_i and last_i come from the counter.
module adcseq_launch
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       tick_half_i,
    input  logic       start_wr_i,
    input  logic       auto_en_i,
    input  logic       trig_i,
    input  logic       diff_i,
    input  logic       free_run_i,
    input  logic       busy_i,
    input  logic       last_i,
    output logic       go_o,
    output logic       auto_go_o,
    output conv_kind_e kind_o,
    output logic       sc_o
);
    logic trig_q, trig_pend_q, sc_q, first_pend_q;
    logic trig_rise, auto_req, sw_req, idle_go, loop_go;

    assign trig_rise = auto_en_i & trig_i & ~trig_q;
    assign auto_req  = trig_rise | trig_pend_q;
    assign sw_req    = start_wr_i | sc_q;
    assign idle_go   = en_i & tick_half_i & ~busy_i & (sw_req | auto_req);
    assign loop_go   = en_i & last_i & free_run_i;
    assign go_o      = idle_go | loop_go;
    assign auto_go_o = idle_go & ~sw_req & auto_req;
    assign sc_o      = sc_q;

    // Choose the timing class of the conversion that starts on this edge.
    always_comb begin
        if (first_pend_q && !last_i) kind_o = KIND_FIRST;
        else if (diff_i)             kind_o = KIND_DIFF;
        else if (auto_go_o)          kind_o = KIND_AUTO;
        else                         kind_o = KIND_NORM;
    end

    // Remember the previous trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    // Hold an idle trigger edge until a half-tick can start the conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                     trig_pend_q <= 1'b0;
        else if (!en_i || go_o)         trig_pend_q <= 1'b0;
        else if (trig_rise && !busy_i)  trig_pend_q <= 1'b1;
    end

    // Arm the long timing while disabled; disarm when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      first_pend_q <= 1'b1;
        else if (!en_i)  first_pend_q <= 1'b1;
        else if (last_i) first_pend_q <= 1'b0;
    end

    // Start bit: set by a start or an idle write, cleared at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sc_q <= 1'b0;
        else if (!en_i)                    sc_q <= 1'b0;
        else if (go_o)                     sc_q <= 1'b1;
        else if (last_i)                   sc_q <= 1'b0;
        else if (start_wr_i && !busy_i)    sc_q <= 1'b1;
    end
endmodule

// File: rtl/adcseq_count.sv
// Half-tick counter of one conversion and its strobe decoder.
// Loads the sample and end points at the start edge and emits the sample,
// per-bit and load strobes. Assumes the end point lies after the last bit.
module adcseq_count
    import adcseq_pkg::*;
#(
    parameter int NBITS      = 10,
    parameter int NORM_SAMP  = 3,
    parameter int NORM_HALF  = 26,
    parameter int FIRST_SAMP = 27,
    parameter int FIRST_HALF = 50,
    parameter int AUTO_SAMP  = 4,
    parameter int AUTO_HALF  = 27,
    parameter int DIFF_SLIP  = 2,
    parameter int CW         = 7,
    parameter int IW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_half_i,
    input  logic          go_i,
    input  conv_kind_e    kind_i,
    input  logic          misalign_i,
    output logic          busy_o,
    output logic          last_o,
    output logic          sample_o,
    output logic          bit_stb_o,
    output logic [IW-1:0] bit_idx_o,
    output logic          load_o
);
    localparam int BW = $clog2(NBITS + 1);
    localparam logic [BW-1:0] NB      = BW'(NBITS);
    localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic [CW-1:0] cnt_q, samp_q, tot_q, cnt_n, since_samp, pick_samp, pick_tot;
    logic [BW-1:0] bitn_q;
    logic          bit_hit;

    assign cnt_n      = cnt_q + ONE;
    assign since_samp = cnt_n - samp_q;
    assign last_o     = busy_o & en_i & tick_half_i & (cnt_n == tot_q);
    assign bit_hit    = busy_o & en_i & tick_half_i & (cnt_n > samp_q)
                      & ~since_samp[0] & (bitn_q < NB);

    // Map the timing class to its sample and end points in half-ticks.
    always_comb begin
        case (kind_i)
            KIND_FIRST: begin
                pick_samp = CW'(FIRST_SAMP);
                pick_tot  = CW'(FIRST_HALF);
            end
            KIND_AUTO: begin
                pick_samp = CW'(AUTO_SAMP);
                pick_tot  = CW'(AUTO_HALF);
            end
            KIND_DIFF: begin
                pick_samp = CW'(NORM_SAMP) + (misalign_i ? CW'(DIFF_SLIP) : '0);
                pick_tot  = CW'(NORM_HALF) + (misalign_i ? CW'(DIFF_SLIP) : '0);
            end
            default: begin
                pick_samp = CW'(NORM_SAMP);
                pick_tot  = CW'(NORM_HALF);
            end
        endcase
    end

    // Run the count and register single-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            cnt_q     <= '0;
            samp_q    <= '0;
            tot_q     <= '0;
            bitn_q    <= '0;
            sample_o  <= 1'b0;
            bit_stb_o <= 1'b0;
            bit_idx_o <= '0;
            load_o    <= 1'b0;
        end else begin
            sample_o  <= 1'b0;
            bit_stb_o <= 1'b0;
            load_o    <= 1'b0;
            if (!en_i) begin
                busy_o <= 1'b0;
            end else if (go_i) begin
                busy_o <= 1'b1;
                cnt_q  <= '0;
                samp_q <= pick_samp;
                tot_q  <= pick_tot;
                bitn_q <= '0;
                if (last_o) load_o <= 1'b1;
            end else if (busy_o && tick_half_i) begin
                cnt_q <= cnt_n;
                if (cnt_n == samp_q) sample_o <= 1'b1;
                if (bit_hit) begin
                    bit_stb_o <= 1'b1;
                    bit_idx_o <= TOP_IDX - IW'(bitn_q);
                    bitn_q    <= bitn_q + BW'(1);
                end
                if (last_o) begin
                    busy_o <= 1'b0;
                    load_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Top of the conversion sequencer: start arbitration, phase alignment and
// strobe counter, plus the sticky completion flag and start markers.
// Assumes tick_half is one-cycle wide at twice the converter clock rate.
module adc_conv_seq
    import adcseq_pkg::*;
#(
    parameter int NBITS      = 10,
    parameter int NORM_SAMP  = 3,
    parameter int NORM_HALF  = 26,
    parameter int FIRST_SAMP = 27,
    parameter int FIRST_HALF = 50,
    parameter int AUTO_SAMP  = 4,
    parameter int AUTO_HALF  = 27,
    parameter int DIFF_SLIP  = 2,
    parameter int PH_W       = 2,
    localparam int IW        = $clog2(NBITS),
    localparam int CW        = $clog2(FIRST_HALF + NORM_HALF + AUTO_HALF + DIFF_SLIP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adc_en,
    input  logic          tick_half,
    input  logic          start_wr,
    input  logic          auto_en,
    input  logic          trig_in,
    input  logic          free_run,
    input  logic          diff_sel,
    input  logic          done_clr,
    output logic          sh_strobe,
    output logic          bit_strobe,
    output logic [IW-1:0] bit_idx,
    output logic          busy,
    output logic          start_bit,
    output logic          result_load,
    output logic          done_flag,
    output logic          chan_latch,
    output logic          psc_reset
);
    logic       go, auto_go, last, misalign;
    conv_kind_e kind;

    adcseq_phase #(.PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .en_i(adc_en), .tick_half_i(tick_half),
        .misalign_o(misalign)
    );

    adcseq_launch u_launch (
        .clk(clk), .rst_n(rst_n), .en_i(adc_en), .tick_half_i(tick_half),
        .start_wr_i(start_wr), .auto_en_i(auto_en), .trig_i(trig_in),
        .diff_i(diff_sel), .free_run_i(free_run), .busy_i(busy),
        .last_i(last), .go_o(go), .auto_go_o(auto_go), .kind_o(kind),
        .sc_o(start_bit)
    );

    adcseq_count #(
        .NBITS(NBITS), .NORM_SAMP(NORM_SAMP), .NORM_HALF(NORM_HALF),
        .FIRST_SAMP(FIRST_SAMP), .FIRST_HALF(FIRST_HALF),
        .AUTO_SAMP(AUTO_SAMP), .AUTO_HALF(AUTO_HALF),
        .DIFF_SLIP(DIFF_SLIP), .CW(CW), .IW(IW)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .en_i(adc_en), .tick_half_i(tick_half),
        .go_i(go), .kind_i(kind), .misalign_i(misalign), .busy_o(busy),
        .last_o(last), .sample_o(sh_strobe), .bit_stb_o(bit_strobe),
        .bit_idx_o(bit_idx), .load_o(result_load)
    );

    // Completion flag: set with the result load, cleared by a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (last)     done_flag <= 1'b1;
        else if (done_clr) done_flag <= 1'b0;
    end

    // Mark each start edge, and trigger starts for the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_latch <= 1'b0;
            psc_reset  <= 1'b0;
        end else begin
            chan_latch <= go;
            psc_reset  <= auto_go;
        end
    end
endmodule

// File: rtl/adc_conv_seq_chk.sv
// Temporal checks on the sequencer ports, attached by bind.
// Assumes the same synchronous active-low reset as the design.
module adc_conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic adc_en,
    input logic done_clr,
    input logic sh_strobe,
    input logic bit_strobe,
    input logic busy,
    input logic start_bit,
    input logic result_load,
    input logic done_flag,
    input logic chan_latch,
    input logic psc_reset
);
    AST_LOAD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        result_load |-> done_flag);                                   // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !done_clr |=> done_flag);                        // R7
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_strobe, bit_strobe, result_load}));              // R6
    AST_STROBE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe || bit_strobe) |-> busy);                          // R3
    AST_BUSY_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_bit);                                          // R8
    AST_PSC_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        psc_reset |-> chan_latch && busy);                            // R4
    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> !busy && !start_bit);                             // R10
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        result_load |-> (busy == chan_latch));                        // R9
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .done_clr(done_clr),
    .sh_strobe(sh_strobe), .bit_strobe(bit_strobe), .busy(busy),
    .start_bit(start_bit), .result_load(result_load), .done_flag(done_flag),
    .chan_latch(chan_latch), .psc_reset(psc_reset)
);

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
module adc_conv_seq_test;
    localparam int NB = 10;

    typedef struct packed {
        logic       use_auto;
        logic       diff;
        logic       mis;
        logic [5:0] samp;
        logic [5:0] tot;
    } vec_t;

    // Conversion classes after the first: start mode, alignment, expected points.
    localparam vec_t VEC [5] = '{
        '{1'b0, 1'b0, 1'b0, 6'd3, 6'd26},   // R3 software single-ended
        '{1'b1, 1'b0, 1'b0, 6'd4, 6'd27},   // R4 trigger started
        '{1'b0, 1'b1, 1'b0, 6'd3, 6'd26},   // R5 differential aligned
        '{1'b0, 1'b1, 1'b1, 6'd5, 6'd28},   // R5 differential late phase
        '{1'b1, 1'b1, 1'b1, 6'd5, 6'd28}    // R5 differential by trigger
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic adc_en = 1'b0, tick_half = 1'b1, start_wr = 1'b0, auto_en = 1'b0;
    logic trig_in = 1'b0, free_run = 1'b0, diff_sel = 1'b0, done_clr = 1'b0;
    logic sh_strobe, bit_strobe, busy, start_bit, result_load, done_flag;
    logic chan_latch, psc_reset;
    logic [3:0] bit_idx;
    logic [1:0] ph_m;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    adc_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .tick_half(tick_half),
        .start_wr(start_wr), .auto_en(auto_en), .trig_in(trig_in),
        .free_run(free_run), .diff_sel(diff_sel), .done_clr(done_clr),
        .sh_strobe(sh_strobe), .bit_strobe(bit_strobe), .bit_idx(bit_idx),
        .busy(busy), .start_bit(start_bit), .result_load(result_load),
        .done_flag(done_flag), .chan_latch(chan_latch), .psc_reset(psc_reset)
    );

    always #10 clk = ~clk;

    // Bench model of the half-rate phase, per R5.
    always @(posedge clk) begin
        if (!rst_n || !adc_en) ph_m <= 2'd0;
        else if (tick_half)    ph_m <= ph_m + 2'd1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Start one conversion and measure its strobe points in half-ticks.
    task automatic run_conv(input bit use_auto, input bit diff, input bit mis,
                            input bit gap, output int samp_k, output int tot_k,
                            output int nbits, output bit order_ok);
        int k, exp_idx;
        @(negedge clk);
        diff_sel  = diff;
        tick_half = 1'b1;
        if (diff) while (ph_m[1] != mis) @(negedge clk);
        if (use_auto) begin auto_en = 1'b1; trig_in = 1'b1; end
        else start_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_wr = 1'b0;
        chk(chan_latch == 1'b1, "R12 chan_latch after start", chan_latch, 1);
        chk(psc_reset == use_auto, "R4 psc_reset on start", psc_reset, use_auto);
        chk(start_bit == 1'b1, "R8 start_bit during conversion", start_bit, 1);
        k = 0; samp_k = -1; tot_k = -1; nbits = 0; order_ok = 1'b1; exp_idx = NB - 1;
        while (tot_k < 0 && k < 200) begin
            if (gap) tick_half = ~tick_half;
            @(posedge clk);
            if (tick_half) k++;
            @(negedge clk);
            if (sh_strobe) samp_k = k;
            if (bit_strobe) begin
                if (int'(bit_idx) != exp_idx) order_ok = 1'b0;
                exp_idx--;
                nbits++;
            end
            if (result_load) tot_k = k;
        end
        tick_half = 1'b1;
        trig_in   = 1'b0;
        auto_en   = 1'b0;
        diff_sel  = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk(done_flag == 1'b0, "R7 flag cleared", done_flag, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int s, t, nb, k;
        bit ok;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({sh_strobe, bit_strobe, busy, start_bit, result_load, done_flag,
             chan_latch, psc_reset} == 8'd0, "R1 outputs in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, start_bit, done_flag, chan_latch} == 4'd0, "R1 after release", start_bit, 0);

        // R2: first conversion after enable
        @(negedge clk); adc_en = 1'b1;
        run_conv(1'b0, 1'b0, 1'b0, 1'b0, s, t, nb, ok);
        chk(s == 27, "R2 first sample point", s, 27);
        chk(t == 50, "R2 first load point", t, 50);
        chk(done_flag == 1'b1, "R7 flag set with load", done_flag, 1);
        @(negedge clk);
        chk(done_flag == 1'b1, "R7 flag held", done_flag, 1);
        clear_flag();

        // Table of conversion classes (R3 R4 R5 R6 R8)
        foreach (VEC[i]) begin
            run_conv(VEC[i].use_auto, VEC[i].diff, VEC[i].mis, 1'b0, s, t, nb, ok);
            chk(s == int'(VEC[i].samp), "R3/R4/R5 sample point", s, int'(VEC[i].samp));
            chk(t == int'(VEC[i].tot), "R3/R4/R5 load point", t, int'(VEC[i].tot));
            chk(nb == NB, "R6 bit strobe count", nb, NB);
            chk(ok, "R6 bit order", ok, 1);
            @(negedge clk);
            chk(start_bit == 1'b0 && busy == 1'b0, "R8 start_bit clears", start_bit, 0);
            clear_flag();
        end

        // R8: start write during a conversion is ignored
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        repeat (5) @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        k = 0;
        while (!result_load && k < 100) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && start_bit == 1'b0, "R8 write while busy ignored", busy, 0);
        clear_flag();

        // R4: trigger edge without auto_en starts nothing
        @(negedge clk); trig_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R4 trigger ignored when disabled", busy, 0);
        trig_in = 1'b0;

        // R9: free-running restart
        @(negedge clk); free_run = 1'b1; start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        k = 0;
        while (!result_load && k < 100) begin @(negedge clk); k++; end
        chk(k == 26, "R9 first free-run load", k, 26);
        chk(chan_latch == 1'b1 && busy == 1'b1, "R9 restart at load", chan_latch, 1);
        free_run = 1'b0;
        k = 0;
        @(negedge clk); k++;
        while (!result_load && k < 100) begin @(negedge clk); k++; end
        chk(k == 26, "R9 load spacing", k, 26);
        chk(busy == 1'b0 && chan_latch == 1'b0, "R9 stops after leaving mode", busy, 0);
        clear_flag();

        // R11: spaced half-ticks
        run_conv(1'b0, 1'b0, 1'b0, 1'b1, s, t, nb, ok);
        chk(s == 3, "R11 sample in half-ticks", s, 3);
        chk(t == 26, "R11 load in half-ticks", t, 26);
        clear_flag();

        // R10: abort on disable, then long first conversion again
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        repeat (10) @(negedge clk);
        adc_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && start_bit == 1'b0, "R10 abort clears busy", busy, 0);
        repeat (30) @(negedge clk);
        chk(done_flag == 1'b0, "R10 no load after abort", done_flag, 0);
        adc_en = 1'b1;
        run_conv(1'b0, 1'b0, 1'b0, 1'b0, s, t, nb, ok);
        chk(s == 27, "R10 first sample after re-enable", s, 27);
        chk(t == 50, "R10 first load after re-enable", t, 50);
        clear_flag();

        finish_run();
    end
endmodule